// File: doc/BRIEF.md
# SPI Flash Generic Command Shifter

This block lets software issue any short command to a serial flash device over a single-line SPI link and collect whatever the device sends back. Software fills a bank of six outgoing byte registers and a bit-count register through a small byte-wide register port. It then writes a command code into the command register. The block lowers chip select, clocks out the bit image most significant bit first, and samples the incoming line on every rising serial clock edge. At the end it copies the received bits into a bank of capture registers, where software reads them back.

Two dedicated short commands bypass the generic path. One reads the device status byte into a status result register. The other writes one status byte taken from the highest outgoing register. Each sends a fixed opcode (parameters `RDSTAT_OP` and `WRSTAT_OP`) and always shifts 16 bits.

A five-state machine sequences every command:
- **IDLE** moves to **CLK_LOW** on an accepted command with a legal length, or to **REJECT** when the generic length is illegal.
- **CLK_LOW** moves to **CLK_HIGH** after `SCLK_HALF` cycles and samples the input line.
- **CLK_HIGH** moves back to **CLK_LOW** after `SCLK_HALF` cycles while bits remain, and to **TRAIL** after the last bit.
- **TRAIL** holds chip select low for one full serial period and then returns to **IDLE**.
- **REJECT** returns to **IDLE** after one cycle.

Top module: `spi_cmd_shifter`

## Requirements
- R1: After reset, chip select (`spi_cs_n`) is high and `spi_sclk` is low. The command register (address 0x00), the status result (address 0x02) and all capture registers (address 0x10+i) read 0.
- R2: Writing 0x04 to the command register while idle starts a generic transfer of N bits, with N taken from the count register (address 0x01). The outgoing byte registers sit at address 0x08+i, i = 0..5. The stream is register 5 first, then registers 4 down to 0, then zero bits, most significant bit first, and exactly N rising serial clock edges occur.
- R3: When a legal generic transfer ends, the capture bank holds the last min(N,48) received bits right-aligned, with zeros above them. Capture register i (address 0x10+i) holds bits 8i+7..8i, so the final received byte lands at index 0.
- R4: While a command runs, the command register reads back its code. It reads 0 once the command has finished.
- R5: Code 0x02 shifts 16 bits, the opcode `RDSTAT_OP` (0x05) followed by 8 bits sampled from the device. The sampled byte goes to the status result at address 0x02, and the capture bank is left unchanged.
- R6: Code 0x20 shifts 16 bits, the opcode `WRSTAT_OP` (0x01) followed by outgoing register 5, whatever the count register holds. It leaves the status result and the capture bank unchanged.
- R7: A generic command with a count of 0 or above 56 finishes without any serial clock edge and without lowering chip select. It leaves the capture bank unchanged.
- R8: Chip select stays low from the start of a transfer until 2*`SCLK_HALF` clock cycles (one serial period) after the final falling serial clock edge, and then rises.
- R9: The serial clock idles low. Each high phase lasts `SCLK_HALF` clock cycles and the clock toggles only while chip select is low. The output line changes only while the serial clock is low.
- R10: A write to the command register while a command runs, or a write of any code other than 0x02, 0x04 or 0x20, starts nothing and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The bench builds the block with `SCLK_HALF` = 3, so every serial phase spans several system clocks and the chip-select tail is long enough to time exactly. `NUM_TX` stays at 6, which keeps every count from 0 to 60 within one sweep, including both illegal ends and the 49..56 range where zero padding follows the outgoing bank. Three outgoing patterns, each paired with its own device response stream, show that the bit order and the capture alignment do not depend on the data.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_LOW,
        ST_CLK_HIGH,
        ST_TRAIL,
        ST_REJECT
    } shift_state_t;

    typedef enum logic [1:0] {
        KIND_GENERIC,
        KIND_RDSTAT,
        KIND_WRSTAT
    } xfer_kind_t;

    localparam logic [7:0] CODE_GENERIC = 8'h04;
    localparam logic [7:0] CODE_RDSTAT  = 8'h02;
    localparam logic [7:0] CODE_WRSTAT  = 8'h20;

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int NUM_TX = 6,
    parameter int ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    input  logic                  done,
    input  logic [NUM_TX*8-1:0]   rx_bits,
    output logic                  start,
    output logic                  start_ok,
    output logic [7:0]            start_len,
    output xfer_kind_t            start_kind,
    output logic [NUM_TX*8-1:0]   tx_flat,
    output logic                  busy
);

    localparam int MAX_BITS  = (NUM_TX + 1) * 8;
    localparam int STAT_LEN  = 16;
    localparam int ADDR_CMD  = 0;
    localparam int ADDR_CNT  = 1;
    localparam int ADDR_STAT = 2;
    localparam int TX_BASE   = 8;
    localparam int CAP_BASE  = 16;

    logic [7:0] tx_q  [NUM_TX];
    logic [7:0] cap_q [NUM_TX];
    logic [7:0] count_q;
    logic [7:0] stat_q;
    logic [7:0] act_code_q;
    logic       act_busy_q;
    logic       act_ok_q;
    xfer_kind_t act_kind_q;
    logic       code_valid;
    logic       cmd_write;

    always_comb begin
        code_valid = 1'b1;
        start_kind = KIND_GENERIC;
        case (reg_wdata)
            CODE_GENERIC: start_kind = KIND_GENERIC;
            CODE_RDSTAT:  start_kind = KIND_RDSTAT;
            CODE_WRSTAT:  start_kind = KIND_WRSTAT;
            default:      code_valid = 1'b0;
        endcase
    end

    assign cmd_write = reg_we && (reg_addr == ADDR_W'(ADDR_CMD));
    assign start     = cmd_write && !act_busy_q && code_valid;
    assign start_len = (start_kind == KIND_GENERIC) ? count_q : 8'(STAT_LEN);
    assign start_ok  = (start_kind != KIND_GENERIC) ||
                       ((count_q != 8'd0) && (count_q <= 8'(MAX_BITS)));
    assign busy      = act_busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_busy_q <= 1'b0;
            act_ok_q   <= 1'b0;
            act_code_q <= 8'h00;
            act_kind_q <= KIND_GENERIC;
        end else if (start) begin
            act_busy_q <= 1'b1;
            act_ok_q   <= start_ok;
            act_code_q <= reg_wdata;
            act_kind_q <= start_kind;
        end else if (done) begin
            act_busy_q <= 1'b0;
            act_code_q <= 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= 8'h00;
            stat_q  <= 8'h00;
            for (int i = 0; i < NUM_TX; i++) begin
                tx_q[i]  <= 8'h00;
                cap_q[i] <= 8'h00;
            end
        end else begin
            if (reg_we && reg_addr == ADDR_W'(ADDR_CNT)) begin
                count_q <= reg_wdata;
            end
            for (int i = 0; i < NUM_TX; i++) begin
                if (reg_we && reg_addr == ADDR_W'(TX_BASE + i)) begin
                    tx_q[i] <= reg_wdata;
                end
            end
            if (done && act_busy_q) begin
                if (act_kind_q == KIND_GENERIC && act_ok_q) begin
                    for (int i = 0; i < NUM_TX; i++) begin
                        cap_q[i] <= rx_bits[8*i +: 8];
                    end
                end
                if (act_kind_q == KIND_RDSTAT) begin
                    stat_q <= rx_bits[7:0];
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_TX; i++) begin
            tx_flat[8*i +: 8] = tx_q[i];
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == ADDR_W'(ADDR_CMD)) begin
            reg_rdata = act_busy_q ? act_code_q : 8'h00;
        end
        if (reg_addr == ADDR_W'(ADDR_CNT)) begin
            reg_rdata = count_q;
        end
        if (reg_addr == ADDR_W'(ADDR_STAT)) begin
            reg_rdata = stat_q;
        end
        for (int i = 0; i < NUM_TX; i++) begin
            if (reg_addr == ADDR_W'(TX_BASE + i)) begin
                reg_rdata = tx_q[i];
            end
            if (reg_addr == ADDR_W'(CAP_BASE + i)) begin
                reg_rdata = cap_q[i];
            end
        end
    end

endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
    import spi_cmd_pkg::*;
#(
    parameter int SCLK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       start_ok,
    input  logic [7:0] start_len,
    output logic       load,
    output logic       sample,
    output logic       shift,
    output logic       done,
    output logic       sclk,
    output logic       cs_n
);

    localparam int HC_W = $clog2(2 * SCLK_HALF) + 1;

    shift_state_t state_q, state_d;
    logic [HC_W-1:0] hc_q;
    logic [7:0]      bits_left_q;
    logic            phase_end;
    logic            trail_end;

    assign phase_end = (hc_q == HC_W'(SCLK_HALF - 1));
    assign trail_end = (hc_q == HC_W'(2 * SCLK_HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = start_ok ? ST_CLK_LOW : ST_REJECT;
                end
            end
            ST_CLK_LOW: begin
                if (phase_end) begin
                    state_d = ST_CLK_HIGH;
                end
            end
            ST_CLK_HIGH: begin
                if (phase_end) begin
                    state_d = (bits_left_q == 8'd0) ? ST_TRAIL : ST_CLK_LOW;
                end
            end
            ST_TRAIL: begin
                if (trail_end) begin
                    state_d = ST_IDLE;
                end
            end
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign load   = (state_q == ST_IDLE) && start && start_ok;
    assign sample = (state_q == ST_CLK_LOW) && phase_end;
    assign shift  = (state_q == ST_CLK_HIGH) && phase_end && (bits_left_q != 8'd0);
    assign done   = ((state_q == ST_TRAIL) && trail_end) || (state_q == ST_REJECT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hc_q        <= '0;
            bits_left_q <= 8'd0;
            sclk        <= 1'b0;
            cs_n        <= 1'b1;
        end else begin
            hc_q <= (state_d != state_q || state_d == ST_IDLE) ? '0 : hc_q + 1'b1;
            if (load) begin
                bits_left_q <= start_len;
            end else if (sample) begin
                bits_left_q <= bits_left_q - 8'd1;
            end
            sclk <= (state_d == ST_CLK_HIGH);
            cs_n <= !(state_d == ST_CLK_LOW || state_d == ST_CLK_HIGH ||
                      state_d == ST_TRAIL);
        end
    end

endmodule

// File: rtl/spi_cmd_shreg.sv
module spi_cmd_shreg
    import spi_cmd_pkg::*;
#(
    parameter int         NUM_TX    = 6,
    parameter logic [7:0] RDSTAT_OP = 8'h05,
    parameter logic [7:0] WRSTAT_OP = 8'h01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  xfer_kind_t           kind,
    input  logic [NUM_TX*8-1:0]  tx_flat,
    input  logic                 shift,
    input  logic                 sample,
    input  logic                 miso,
    output logic                 mosi,
    output logic [NUM_TX*8-1:0]  rx_bits
);

    localparam int RX_W  = NUM_TX * 8;
    localparam int IMG_W = RX_W + 8;

    logic [IMG_W-1:0] img_generic;
    logic [IMG_W-1:0] img_sel;
    logic [IMG_W-1:0] tx_sr;

    for (genvar j = 0; j < NUM_TX; j++) begin : g_img
        assign img_generic[IMG_W-1-8*j -: 8] = tx_flat[8*(NUM_TX-1-j) +: 8];
    end
    assign img_generic[7:0] = 8'h00;

    always_comb begin
        case (kind)
            KIND_RDSTAT: img_sel = {RDSTAT_OP, {(IMG_W-8){1'b0}}};
            KIND_WRSTAT: img_sel = {WRSTAT_OP, tx_flat[RX_W-1 -: 8], {(IMG_W-16){1'b0}}};
            default:     img_sel = img_generic;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            rx_bits <= '0;
        end else if (load) begin
            tx_sr   <= img_sel;
            rx_bits <= '0;
        end else begin
            if (shift) begin
                tx_sr <= {tx_sr[IMG_W-2:0], 1'b0};
            end
            if (sample) begin
                rx_bits <= {rx_bits[RX_W-2:0], miso};
            end
        end
    end

    assign mosi = tx_sr[IMG_W-1];

endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
    import spi_cmd_pkg::*;
#(
    parameter int         NUM_TX    = 6,
    parameter int         ADDR_W    = 5,
    parameter int         SCLK_HALF = 2,
    parameter logic [7:0] RDSTAT_OP = 8'h05,
    parameter logic [7:0] WRSTAT_OP = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    logic                start, start_ok, load, sample, shift, done, cmd_busy;
    logic [7:0]          start_len;
    xfer_kind_t          start_kind;
    logic [NUM_TX*8-1:0] tx_flat, rx_bits;

    spi_cmd_regs #(.NUM_TX(NUM_TX), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .done(done), .rx_bits(rx_bits),
        .start(start), .start_ok(start_ok), .start_len(start_len),
        .start_kind(start_kind), .tx_flat(tx_flat), .busy(cmd_busy)
    );

    spi_cmd_fsm #(.SCLK_HALF(SCLK_HALF)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_ok(start_ok), .start_len(start_len),
        .load(load), .sample(sample), .shift(shift), .done(done),
        .sclk(spi_sclk), .cs_n(spi_cs_n)
    );

    spi_cmd_shreg #(.NUM_TX(NUM_TX), .RDSTAT_OP(RDSTAT_OP), .WRSTAT_OP(WRSTAT_OP)) u_shreg (
        .clk(clk), .rst_n(rst_n),
        .load(load), .kind(start_kind), .tx_flat(tx_flat),
        .shift(shift), .sample(sample), .miso(spi_miso),
        .mosi(spi_mosi), .rx_bits(rx_bits)
    );

endmodule

// File: rtl/spi_cmd_shifter_chk.sv
module spi_cmd_shifter_chk #(
    parameter int SCLK_HALF = 2
) (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic cs_n,
    input logic mosi,
    input logic busy
);

    logic [7:0] hi_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q <= 8'd0;
        end else begin
            hi_run_q <= sclk ? hi_run_q + 8'd1 : 8'd0;
        end
    end

    p_sclk_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    p_high_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run_q <= 8'(SCLK_HALF));

    p_mosi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    p_frame_in_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    p_end_releases_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> cs_n);

endmodule

bind spi_cmd_shifter spi_cmd_shifter_chk #(.SCLK_HALF(SCLK_HALF)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n),
    .mosi(spi_mosi), .busy(cmd_busy)
);

// File: tb/tb_spi_cmd_shifter.sv
module tb_spi_cmd_shifter;

    localparam int HALF   = 3;
    localparam int NTX    = 6;
    localparam int PERIOD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_sclk, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;

    int   nchk = 0, nfail = 0, cyc = 0;
    int   rises = 0, bitpos = 0;
    logic mosi_log [64];
    time  t_fall = 0, t_csr = 0;
    logic [7:0] seed = 8'h01;
    logic [7:0] txv [NTX];
    logic [7:0] exp_cap [NTX];
    logic [7:0] exp_stat = 8'h00;

    spi_cmd_shifter #(.SCLK_HALF(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mbyte(int j);
        return 8'hA5 ^ 8'(j * 59) ^ seed;
    endfunction

    function automatic logic miso_bit(int k);
        logic [7:0] b = mbyte(k / 8);
        return b[7 - (k % 8)];
    endfunction

    // device model
    always @(negedge spi_cs_n) begin
        bitpos = 0;
        spi_miso = miso_bit(0);
    end
    always @(posedge spi_sclk) begin
        if (rises < 64) mosi_log[rises] = spi_mosi;
        rises++;
    end
    always @(negedge spi_sclk) begin
        t_fall = $time;
        bitpos++;
        spi_miso = miso_bit(bitpos);
    end
    always @(posedge spi_cs_n) t_csr = $time;

    task automatic chk(string rq, logic [31:0] act, logic [31:0] expv);
        nchk++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // issue a command, check busy readback, wait until done
    task automatic run_cmd(logic [7:0] code, string rq);
        logic [7:0] v;
        rises = 0;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'h00; reg_wdata = code;
        @(negedge clk);
        reg_we = 1'b0;
        #1 chk({rq, " R4 busy code"}, reg_rdata, code);
        for (int w = 0; w < 3000; w++) begin
            rd(5'h00, v);
            if (v == 8'h00) break;
        end
        chk("R4 done reads 0", v, 8'h00);
    endtask

    task automatic check_caps(string rq);
        logic [7:0] v;
        for (int i = 0; i < NTX; i++) begin
            rd(5'(16 + i), v);
            chk(rq, v, exp_cap[i]);
        end
    endtask

    task automatic generic_case(int n);
        logic [55:0] img;
        logic [47:0] r;
        int bad;
        bit legal;
        legal = (n >= 1) && (n <= 56);
        wr(5'h01, 8'(n));
        run_cmd(8'h04, "R2");
        if (!legal) begin
            chk("R7 no sclk for illegal count", rises, 0);
            check_caps("R7 capture unchanged");
        end else begin
            chk("R2 sclk edge count", rises, n);
            img = {txv[5], txv[4], txv[3], txv[2], txv[1], txv[0], 8'h00};
            bad = 0;
            for (int k = 0; k < n; k++) if (mosi_log[k] !== img[55-k]) bad++;
            chk("R2 mosi stream mismatches", bad, 0);
            chk("R8 cs tail in clocks", 32'((t_csr - t_fall) / PERIOD), 2 * HALF);
            r = '0;
            for (int k = 0; k < n; k++) r = {r[46:0], miso_bit(k)};
            for (int i = 0; i < NTX; i++) exp_cap[i] = r[8*i +: 8];
            check_caps("R3 capture byte");
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                nfail++;
                $display("FAIL watchdog all requirements actual=%0d expected<190000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 cs_n high", spi_cs_n, 1'b1);
        chk("R1 sclk low", spi_sclk, 1'b0);
        rd(5'h00, v); chk("R1 cmd reg", v, 8'h00);
        rd(5'h02, v); chk("R1 status result", v, 8'h00);
        for (int i = 0; i < NTX; i++) exp_cap[i] = 8'h00;
        check_caps("R1 capture reset");

        // R2 R3 R7 R8 sweep of all counts over three patterns
        for (int p = 0; p < 3; p++) begin
            seed = 8'(p * 39 + 1);
            for (int i = 0; i < NTX; i++) begin
                txv[i] = 8'(i * 17 + p * 90) ^ 8'hC3;
                wr(5'(8 + i), txv[i]);
            end
            for (int n = 0; n <= 60; n++) generic_case(n);
        end

        // R5 read status
        seed = 8'h5C;
        run_cmd(8'h02, "R5");
        chk("R5 sclk edges", rises, 16);
        v = '0;
        for (int k = 0; k < 8; k++) v = {v[6:0], mosi_log[k]};
        chk("R5 opcode sent", v, 8'h05);
        exp_stat = mbyte(1);
        rd(5'h02, v); chk("R5 status byte", v, exp_stat);
        check_caps("R5 capture unchanged");

        // R6 write status, count deliberately not 8
        wr(5'h01, 8'd40);
        wr(5'h0D, 8'h9E);
        run_cmd(8'h20, "R6");
        chk("R6 sclk edges", rises, 16);
        v = '0;
        for (int k = 0; k < 8; k++) v = {v[6:0], mosi_log[k]};
        chk("R6 opcode sent", v, 8'h01);
        v = '0;
        for (int k = 8; k < 16; k++) v = {v[6:0], mosi_log[k]};
        chk("R6 status value sent", v, 8'h9E);
        rd(5'h02, v); chk("R6 status result unchanged", v, exp_stat);
        check_caps("R6 capture unchanged");

        // R10 unknown code ignored
        rises = 0;
        wr(5'h00, 8'h7F);
        #1 chk("R10 unknown code not busy", reg_rdata, 8'h00);
        repeat (20) @(negedge clk);
        chk("R10 unknown code no sclk", rises, 0);
        chk("R10 unknown code cs high", spi_cs_n, 1'b1);

        // R10 command write while busy ignored
        wr(5'h01, 8'd24);
        rises = 0;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'h00; reg_wdata = 8'h04;
        @(negedge clk);
        reg_wdata = 8'h02;
        @(negedge clk);
        reg_we = 1'b0;
        #1 chk("R10 busy code kept", reg_rdata, 8'h04);
        repeat (400) @(negedge clk);
        chk("R10 only first command ran", rises, 24);
        rd(5'h00, v); chk("R10 idle after", v, 8'h00);
        rd(5'h02, v); chk("R10 status untouched", v, exp_stat);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule